// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline. It detects one case: the instruction in execute is a load, and the instruction in decode names the load's destination as one of its two source registers. Forwarding cannot supply that value in time, because the loaded data only exists after the memory stage. When the case occurs, the unit holds the program counter and the fetch/decode latch for one cycle. In the same cycle it sends a no-op into execute by clearing the register-write and memory-write control bits of the instruction entering that stage. The opcode and the memory-read bit pass through unchanged. Every other dependency is left to forwarding and never stalls.

A two-state machine sequences the stall. In `HZ_SCAN` the comparator result is examined each cycle. A hit raises the stall outputs in that cycle and takes the transition SCAN→FREEZE. With no hit the machine takes SCAN→SCAN. In `HZ_FREEZE` execute holds the bubble copy of the stalled consumer, so no stall is raised, and the unconditional transition FREEZE→SCAN follows. This keeps every stall exactly one cycle long, even when the bubble's own fields would match the frozen consumer again. An asynchronous active-low reset returns the machine to `HZ_SCAN`.

Top module: `load_use_stall_unit`

## Requirements
- R1: While rst_n is low, pc_we and ifid_we are 1 and ctrl_zero is 0 whatever the inputs. In the first cycle after release, a hazard stalls.
- R2: When ex_mem_read is 1, ex_dst is nonzero and ex_dst equals id_rs, and the previous cycle was not a stall, then pc_we and ifid_we are 0 and ctrl_zero is 1 in that same cycle. pc_we and ifid_we are always equal, and ctrl_zero is always their inverse.
- R3: The same stall happens when ex_dst equals id_rt instead of id_rs.
- R4: When ex_mem_read is 0, no stall is raised, even if ex_dst equals a source field.
- R5: When ex_dst is 0 (register zero), no stall is raised.
- R6: The cycle after a stall never stalls, even if the inputs still match. A match present in the cycle after that stalls again.
- R7: While ctrl_zero is 1, ex_reg_write_o and ex_mem_write_o are 0, and ex_opcode_o and ex_mem_read_o equal id_opcode and id_mem_read.
- R8: When ctrl_zero is 0, all four ex_*_o outputs equal their id_* inputs. A load whose destination matches neither source does not stall.
- R9: The sequence load r2←[r1]; add r3←r3+r2; load r4←[r2+r3]; sub r4←r5−r3 runs through the five-stage model in n+k−1+stalls = 4+5−1+1 = 9 cycles, with exactly one stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_mem_read | input | 1 | Execute-stage instruction reads memory (is a load) |
| ex_dst | input | 5 | Destination register of the execute-stage instruction |
| id_rs | input | 5 | First source register field in the fetch/decode latch |
| id_rt | input | 5 | Second source register field in the fetch/decode latch |
| id_opcode | input | 6 | Opcode of the instruction being decoded |
| id_mem_read | input | 1 | Memory-read control of the decoded instruction |
| id_reg_write | input | 1 | Register-write control of the decoded instruction |
| id_mem_write | input | 1 | Memory-write control of the decoded instruction |
| pc_we | output | 1 | Program counter write enable (0 freezes fetch) |
| ifid_we | output | 1 | Fetch/decode latch write enable |
| ctrl_zero | output | 1 | High when the controls entering execute are zeroed |
| ex_opcode_o | output | 6 | Opcode sent toward execute |
| ex_mem_read_o | output | 1 | Memory-read control sent toward execute |
| ex_reg_write_o | output | 1 | Register-write control sent toward execute |
| ex_mem_write_o | output | 1 | Memory-write control sent toward execute |

## Verification
The bench repeats a matching hazard on back-to-back cycles. A unit without the freeze state would stall twice and lose a cycle on every load-use pair. It also covers a load that writes register zero, which a comparator without the zero guard would stall on for nothing. It covers a non-load whose destination matches, which a unit that ignored the memory-read flag would stall on, undoing forwarding. It drives the rt field alone, to catch a comparator wired only to rs. Finally, it runs the four-instruction sequence through a small pipeline model. A missing stall, a double stall or a frozen latch that leaks would move the last write-back away from cycle 9.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

    typedef enum logic [0:0] {
        HZ_SCAN   = 1'b0,
        HZ_FREEZE = 1'b1
    } hzu_state_e;

    typedef struct packed {
        logic mem_read;
        logic reg_write;
        logic mem_write;
    } hzu_ctl_t;

endpackage

// File: rtl/hzu_match.sv
module hzu_match #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic             ld_in_ex,
    input  logic [AW-1:0]    ld_dst,
    input  logic [NSRC*AW-1:0] srcs,
    output logic             hit
);
    logic [NSRC-1:0] eq;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign eq[g] = (srcs[g*AW +: AW] == ld_dst);
    end

    // register zero is hard-wired, a load to it produces nothing to wait for
    assign hit = ld_in_ex && (ld_dst != '0) && (|eq);
endmodule

// File: rtl/hzu_seq.sv
module hzu_seq
    import hzu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic pc_we,
    output logic ifid_we,
    output logic ctrl_zero
);
    hzu_state_e state_q;
    hzu_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HZ_SCAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        pc_we     = 1'b1;
        ifid_we   = 1'b1;
        ctrl_zero = 1'b0;
        unique case (state_q)
            HZ_SCAN: begin
                if (hit && rst_n) begin
                    pc_we     = 1'b0;
                    ifid_we   = 1'b0;
                    ctrl_zero = 1'b1;
                    state_d   = HZ_FREEZE;
                end
            end
            HZ_FREEZE: begin
                // execute now holds the bubble; decode holds the consumer again
                state_d = HZ_SCAN;
            end
            default: state_d = HZ_SCAN;
        endcase
    end
endmodule

// File: rtl/hzu_bubble.sv
module hzu_bubble
    import hzu_pkg::*;
#(
    parameter int OPC_W = 6
) (
    input  logic             zero_ctl,
    input  logic [OPC_W-1:0] opc_in,
    input  hzu_ctl_t         ctl_in,
    output logic [OPC_W-1:0] opc_out,
    output hzu_ctl_t         ctl_out
);
    always_comb begin
        opc_out = opc_in;
        ctl_out = ctl_in;
        if (zero_ctl) begin
            ctl_out.reg_write = 1'b0;
            ctl_out.mem_write = 1'b0;
        end
    end
endmodule

// File: rtl/load_use_stall_unit.sv
module load_use_stall_unit
    import hzu_pkg::*;
#(
    parameter int AW    = 5,
    parameter int OPC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ex_mem_read,
    input  logic [AW-1:0]    ex_dst,
    input  logic [AW-1:0]    id_rs,
    input  logic [AW-1:0]    id_rt,
    input  logic [OPC_W-1:0] id_opcode,
    input  logic             id_mem_read,
    input  logic             id_reg_write,
    input  logic             id_mem_write,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             ctrl_zero,
    output logic [OPC_W-1:0] ex_opcode_o,
    output logic             ex_mem_read_o,
    output logic             ex_reg_write_o,
    output logic             ex_mem_write_o
);
    localparam int NSRC = 2;

    logic     hit;
    hzu_ctl_t ctl_in;
    hzu_ctl_t ctl_out;

    hzu_match #(.AW(AW), .NSRC(NSRC)) u_match (
        .ld_in_ex (ex_mem_read),
        .ld_dst   (ex_dst),
        .srcs     ({id_rt, id_rs}),
        .hit      (hit)
    );

    hzu_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .pc_we     (pc_we),
        .ifid_we   (ifid_we),
        .ctrl_zero (ctrl_zero)
    );

    assign ctl_in = '{mem_read: id_mem_read, reg_write: id_reg_write, mem_write: id_mem_write};

    hzu_bubble #(.OPC_W(OPC_W)) u_bubble (
        .zero_ctl (ctrl_zero),
        .opc_in   (id_opcode),
        .ctl_in   (ctl_in),
        .opc_out  (ex_opcode_o),
        .ctl_out  (ctl_out)
    );

    assign ex_mem_read_o  = ctl_out.mem_read;
    assign ex_reg_write_o = ctl_out.reg_write;
    assign ex_mem_write_o = ctl_out.mem_write;
endmodule

// File: rtl/load_use_stall_unit_chk.sv
module load_use_stall_unit_chk #(
    parameter int AW    = 5,
    parameter int OPC_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ex_mem_read,
    input logic [AW-1:0]    ex_dst,
    input logic [AW-1:0]    id_rs,
    input logic [AW-1:0]    id_rt,
    input logic [OPC_W-1:0] id_opcode,
    input logic             id_mem_read,
    input logic             id_reg_write,
    input logic             id_mem_write,
    input logic             pc_we,
    input logic             ifid_we,
    input logic             ctrl_zero,
    input logic [OPC_W-1:0] ex_opcode_o,
    input logic             ex_mem_read_o,
    input logic             ex_reg_write_o,
    input logic             ex_mem_write_o
);
    assert_quiet_in_reset_R1: assert property (@(posedge clk)
        (rst_n === 1'b0) |-> (pc_we && ifid_we && !ctrl_zero));

    assert_rs_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_mem_read && ex_dst != '0 && ex_dst == id_rs && !$past(ctrl_zero)) |-> ctrl_zero);

    assert_freeze_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we == ifid_we) && (ctrl_zero == !pc_we));

    assert_rt_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_mem_read && ex_dst != '0 && ex_dst == id_rt && !$past(ctrl_zero)) |-> ctrl_zero);

    assert_no_stall_nonload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_mem_read |-> (pc_we && !ctrl_zero));

    assert_no_stall_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == '0) |-> !ctrl_zero);

    assert_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero |=> !ctrl_zero);

    assert_bubble_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero |-> (!ex_reg_write_o && !ex_mem_write_o &&
                       ex_opcode_o == id_opcode && ex_mem_read_o == id_mem_read));

    assert_pass_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_zero |-> (ex_reg_write_o == id_reg_write && ex_mem_write_o == id_mem_write &&
                        ex_opcode_o == id_opcode && ex_mem_read_o == id_mem_read));
endmodule

bind load_use_stall_unit load_use_stall_unit_chk #(.AW(AW), .OPC_W(OPC_W)) u_chk (.*);

// File: tb/load_use_stall_unit_tb_top.sv
module load_use_stall_unit_tb_top;
    localparam int AW = 5;
    localparam int OW = 6;
    localparam int NV = 12;

    // fields: req[29:26] mr[25] dst[24:20] rs[19:15] rt[14:10] idmr[9] rw[8] mw[7] op[6:1] stall[0]
    localparam logic [29:0] VEC [NV] = '{
        {4'd4, 1'b0, 5'd3,  5'd3,  5'd0,  1'b0, 1'b1, 1'b0, 6'h00, 1'b0}, // R4 non-load match
        {4'd2, 1'b1, 5'd3,  5'd3,  5'd7,  1'b0, 1'b1, 1'b0, 6'h00, 1'b1}, // R2 rs hit
        {4'd6, 1'b1, 5'd3,  5'd3,  5'd7,  1'b0, 1'b1, 1'b0, 6'h00, 1'b0}, // R6 freeze cycle
        {4'd3, 1'b1, 5'd9,  5'd1,  5'd9,  1'b1, 1'b1, 1'b0, 6'h23, 1'b1}, // R3 rt hit
        {4'd6, 1'b1, 5'd9,  5'd1,  5'd9,  1'b1, 1'b1, 1'b0, 6'h23, 1'b0}, // R6 freeze cycle
        {4'd4, 1'b0, 5'd9,  5'd9,  5'd9,  1'b0, 1'b1, 1'b1, 6'h11, 1'b0}, // R4 both match, no load
        {4'd5, 1'b1, 5'd0,  5'd0,  5'd0,  1'b0, 1'b1, 1'b1, 6'h08, 1'b0}, // R5 dest zero
        {4'd8, 1'b1, 5'd12, 5'd4,  5'd5,  1'b0, 1'b1, 1'b1, 6'h0c, 1'b0}, // R8 load, no match
        {4'd7, 1'b1, 5'd31, 5'd31, 5'd31, 1'b0, 1'b0, 1'b1, 6'h2b, 1'b1}, // R7 store bubbled
        {4'd6, 1'b1, 5'd31, 5'd31, 5'd31, 1'b0, 1'b0, 1'b1, 6'h2b, 1'b0}, // R6 freeze cycle
        {4'd6, 1'b1, 5'd31, 5'd31, 5'd31, 1'b1, 1'b1, 1'b1, 6'h3f, 1'b1}, // R6 stalls again
        {4'd8, 1'b0, 5'd31, 5'd31, 5'd31, 1'b1, 1'b1, 1'b1, 6'h3f, 1'b0}  // R8 pass-through
    };

    // four-instruction program: lw r2; add r3; lw r4; sub r4
    localparam logic [AW-1:0] P_RS  [4] = '{5'd1, 5'd3, 5'd2, 5'd5};
    localparam logic [AW-1:0] P_RT  [4] = '{5'd2, 5'd2, 5'd3, 5'd3};
    localparam logic [AW-1:0] P_DST [4] = '{5'd2, 5'd3, 5'd4, 5'd4};
    localparam logic          P_LD  [4] = '{1'b1, 1'b0, 1'b1, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          t_mr = 1'b0, t_idmr = 1'b0, t_rw = 1'b0, t_mw = 1'b0;
    logic [AW-1:0] t_dst = '0, t_rs = '0, t_rt = '0;
    logic [OW-1:0] t_op = '0;

    logic          pipe_on = 1'b0;
    int            pc, ifid_i, ex_i, mem_i, wb_i, cyc, stalls;
    logic          ifid_v, ex_v, mem_v, wb_v, m_ex_mr;
    logic [AW-1:0] m_ex_dst;

    logic          ex_mem_read, id_mem_read;
    logic [AW-1:0] ex_dst, id_rs, id_rt;
    logic          pc_we, ifid_we, ctrl_zero, ex_mem_read_o, ex_reg_write_o, ex_mem_write_o;
    logic [OW-1:0] ex_opcode_o;

    assign ex_mem_read = pipe_on ? m_ex_mr  : t_mr;
    assign ex_dst      = pipe_on ? m_ex_dst : t_dst;
    assign id_rs       = pipe_on ? (ifid_v ? P_RS[ifid_i] : '0) : t_rs;
    assign id_rt       = pipe_on ? (ifid_v ? P_RT[ifid_i] : '0) : t_rt;
    assign id_mem_read = pipe_on ? (ifid_v && P_LD[ifid_i]) : t_idmr;

    load_use_stall_unit #(.AW(AW), .OPC_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ex_mem_read(ex_mem_read), .ex_dst(ex_dst),
        .id_rs(id_rs), .id_rt(id_rt), .id_opcode(t_op), .id_mem_read(id_mem_read),
        .id_reg_write(t_rw), .id_mem_write(t_mw), .pc_we(pc_we), .ifid_we(ifid_we),
        .ctrl_zero(ctrl_zero), .ex_opcode_o(ex_opcode_o), .ex_mem_read_o(ex_mem_read_o),
        .ex_reg_write_o(ex_reg_write_o), .ex_mem_write_o(ex_mem_write_o)
    );

    // behavioural PC and stage latches driven by the unit's enables
    always @(posedge clk) begin
        if (!pipe_on) begin
            pc <= 0; ifid_v <= 1'b0; ifid_i <= 0; ex_v <= 1'b0; ex_i <= 0; m_ex_mr <= 1'b0;
            m_ex_dst <= '0; mem_v <= 1'b0; mem_i <= 0; wb_v <= 1'b0; wb_i <= 0;
            cyc <= 1; stalls <= 0;
        end else begin
            if (pc_we) pc <= pc + 1;
            if (ifid_we) begin
                ifid_v <= (pc < 4);
                ifid_i <= (pc < 4) ? pc : 0;
            end
            ex_v     <= ifid_v && !ctrl_zero;
            ex_i     <= ifid_i;
            m_ex_mr  <= ifid_v && ex_mem_read_o;
            m_ex_dst <= ifid_v ? P_DST[ifid_i] : '0;
            mem_v <= ex_v;  mem_i <= ex_i;
            wb_v  <= mem_v; wb_i  <= mem_i;
            cyc <= cyc + 1;
            if (!pc_we) stalls <= stalls + 1;
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_out();
        return {20'd0, pc_we, ifid_we, ctrl_zero, ex_mem_read_o, ex_reg_write_o, ex_mem_write_o, ex_opcode_o};
    endfunction

    initial begin
        #(20 * 5000);
        n_fail++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: hazard inputs present during reset, no stall may show
        t_mr = 1'b1; t_dst = 5'd3; t_rs = 5'd3; t_rt = 5'd0; t_rw = 1'b1; t_op = 6'h05;
        repeat (3) @(negedge clk);
        chk("R1 reset stall outputs", {29'd0, pc_we, ifid_we, ctrl_zero}, 32'b110);
        rst_n = 1'b1;
        #5;
        chk("R1 stall right after reset", {31'd0, ctrl_zero}, 32'd1);
        @(negedge clk); #5;
        chk("R6 no second stall after reset hit", {31'd0, ctrl_zero}, 32'd0);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            logic [31:0] exp;
            v = VEC[i];
            t_mr = v[25]; t_dst = v[24:20]; t_rs = v[19:15]; t_rt = v[14:10];
            t_idmr = v[9]; t_rw = v[8]; t_mw = v[7]; t_op = v[6:1];
            #5;
            if (v[0]) exp = {20'd0, 1'b0, 1'b0, 1'b1, v[9], 1'b0, 1'b0, v[6:1]};
            else      exp = {20'd0, 1'b1, 1'b1, 1'b0, v[9], v[8], v[7], v[6:1]};
            chk($sformatf("R%0d vector %0d", v[29:26], i), pack_out(), exp);
            @(negedge clk);
        end

        // R9: pipeline run, fresh reset first
        t_mr = 1'b0; t_rw = 1'b0; t_mw = 1'b0; t_op = '0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        pipe_on = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (wb_v && wb_i == 3) break;
        end
        chk("R9 last write-back cycle", cyc, 32'd9);
        chk("R9 stall cycles", stalls, 32'd1);
        pipe_on = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule